// File: doc/BRIEF.md
# Configuration Control Register Dispatcher

This block is a small register-mapped unit that turns a packed command word from software into a decoded, validated transaction. It holds three 32-bit registers: a data register, a control register and a status register. The register bus has an address, a write strobe, write data and a combinational read-data return. Every access completes in one cycle, with no wait states.

Software places a command in the control word and sets the start bit. In that write cycle the block splits the word into its fields and checks each one. It then records the outcome in the status register as a "complete" flag and an "error" flag. Only two commands are accepted, and both are writes to the main board, device 0:

- a shutdown command, which drives a one-cycle `shutdown_req` pulse;
- a reboot command, which drives a one-cycle `reboot_req` pulse.

Every other command ends with the error flag set, and every read command does too. The system logic that consumes the two pulses lies outside this block.

Top module: `cfg_dispatch`

## Requirements
- R1: After reset, the data, control and status registers all read as zero, and both request outputs are low.
- R2: A write to the control register (offset 0x4) stores the word with bit 31 (start) and bits 19:18 forced to zero. Those bits always read back as zero.
- R3: The data register (offset 0x0) stores any 32-bit value written to it and returns that value on read. A launched transaction never changes it.
- R4: A control write with bit 31 set launches a transaction, and the status register (offset 0x8) then reads 1 or 3 (bit 0 = complete, bit 1 = error). A control write with bit 31 clear leaves the status unchanged.
- R5: A launched transaction is rejected with status 3 and no request pulse in each of these cases:
  - the 4-bit field at bits 29:26 is non-zero;
  - the position field at bits 15:12 is non-zero;
  - the site field at bits 17:16 is 2 or 3.
- R6: A launch with all of the following raises `shutdown_req` in the cycle after the write, and the status reads 1:
  - bit 30 = 1 (write);
  - function field bits 25:20 = 8;
  - site = 0;
  - device field bits 11:0 = 0;
  - no rejection under R5.
- R7: A launch that meets the same conditions as R6 but with function 9 raises `reboot_req` in the cycle after the write, and the status reads 1.
- R8: Any other launched write, and every launched read (bit 30 = 0), completes with status 3 and raises no request. This includes functions 8 and 9 sent to site 1 or to a non-zero device.
- R9: Each request is high only in the cycle that follows a qualifying launch. The two requests are never high together.
- R10: A write to an address other than 0x0, 0x4 or 0x8 changes no register, and a read from such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
Two things can fall in the same cycle: the request pulse from one launch, and the decode and status update of a second launch written straight after it. The bench issues back-to-back control writes, for example shutdown then reboot, and shutdown then a rejected command. In each following cycle it checks that exactly the pulse belonging to the previous write is high and that the status matches the most recent launch. Random command words, biased toward the accepted encodings, then mix launches, plain field updates and data writes. A bench model predicts the status and pulses for each one.

// File: rtl/cfg_dispatch.sv
module cfg_dispatch #(
  parameter int ADDR_W      = 4,
  parameter int OFF_DATA    = 0,
  parameter int OFF_CTRL    = 4,
  parameter int OFF_STAT    = 8,
  parameter int FN_SHUTDOWN = 8,
  parameter int FN_REBOOT   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              shutdown_req,
  output logic              reboot_req
);
  localparam logic [31:0]       CTRL_KEEP = 32'h7FF3_FFFF;
  localparam logic [ADDR_W-1:0] A_DATA    = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(OFF_STAT);
  localparam logic [5:0]        F_SHUT    = 6'(FN_SHUTDOWN);
  localparam logic [5:0]        F_BOOT    = 6'(FN_REBOOT);

  logic [31:0] data_q, ctrl_q;
  logic [1:0]  stat_q;
  logic        shut_q, boot_q;

  wire sel_data = bus_addr == A_DATA;
  wire sel_ctrl = bus_addr == A_CTRL;
  wire launch   = bus_wr && sel_ctrl && bus_wdata[31];

  wire        c_wr   = bus_wdata[30];
  wire [3:0]  c_dcc  = bus_wdata[29:26];
  wire [5:0]  c_fn   = bus_wdata[25:20];
  wire [1:0]  c_site = bus_wdata[17:16];
  wire [3:0]  c_pos  = bus_wdata[15:12];
  wire [11:0] c_dev  = bus_wdata[11:0];

  wire fields_ok = (c_dcc == '0) && (c_pos == '0) && (c_site <= 2'd1);
  wire mb_dev0   = (c_site == 2'd0) && (c_dev == '0);
  wire cmd_ok    = c_wr && fields_ok && mb_dev0;
  wire do_shut   = launch && cmd_ok && (c_fn == F_SHUT);
  wire do_boot   = launch && cmd_ok && (c_fn == F_BOOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
      shut_q <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      if (bus_wr && sel_data) data_q <= bus_wdata;
      if (bus_wr && sel_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
      if (launch) stat_q <= {~(do_shut | do_boot), 1'b1};
      shut_q <= do_shut;
      boot_q <= do_boot;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = data_q;
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {30'd0, stat_q};
      default: bus_rdata = '0;
    endcase
  end

  assign shutdown_req = shut_q;
  assign reboot_req   = boot_q;

  AST_LAUNCH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> stat_q[0]);  // R4
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(stat_q));  // R4
  AST_REJECT_DCC: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && bus_wdata[29:26] != 4'd0) |=> (stat_q == 2'b11 && !shutdown_req && !reboot_req));  // R5
  AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> ($past(launch) && stat_q == 2'b01));  // R6
  AST_BOOT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |-> ($past(launch) && stat_q == 2'b01));  // R7
  AST_READ_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !bus_wdata[30]) |=> (!shutdown_req && !reboot_req && stat_q == 2'b11));  // R8
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reboot_req));  // R9
  AST_CTRL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_ctrl) |=> (ctrl_q[31] == 1'b0 && ctrl_q[19:18] == 2'b00));  // R2
endmodule

// File: tb/test_cfg_dispatch.sv
module test_cfg_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        shutdown_req, reboot_req;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] m_data = '0, m_ctrl = '0, m_stat = '0;

  cfg_dispatch i_cfg_dispatch (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req)
  );

  always #10 clk = ~clk;

  function automatic logic [1:0] exp_req(input logic [31:0] w);
    logic ok;
    ok = w[31] && w[30] && w[29:26] == 0 && w[15:12] == 0 && w[17:16] == 0 && w[11:0] == 0;
    if (ok && w[25:20] == 6'd8) return 2'b01;
    if (ok && w[25:20] == 6'd9) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a; bus_wr = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 4'h0) m_data = d;
    if (a == 4'h4) begin
      m_ctrl = d & 32'h7FF3_FFFF;
      if (d[31]) m_stat = (exp_req(d) != 0) ? 32'd1 : 32'd3;
    end
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] v;
    rd(4'h0, v); check({tag, " R3 data"}, v, m_data);
    rd(4'h4, v); check({tag, " R2 ctrl"}, v, m_ctrl);
    rd(4'h8, v); check({tag, " R4 status"}, v, m_stat);
  endtask

  task automatic launch_chk(input string tag, input logic [31:0] w);
    wr(4'h4, w);
    check({tag, " R9 req"}, {30'd0, reboot_req, shutdown_req}, {30'd0, exp_req(w)});
    check_regs(tag);
    @(negedge clk);
    check({tag, " R9 pulse end"}, {30'd0, reboot_req, shutdown_req}, 32'd0);
  endtask

  function automatic logic [31:0] mk(input bit st, input bit w, input logic [3:0] dcc,
      input logic [5:0] fn, input logic [1:0] site, input logic [3:0] pos, input logic [11:0] dev);
    return {st, w, dcc, fn, 2'b00, site, pos, dev};
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset req", {30'd0, reboot_req, shutdown_req}, 32'd0);
    check_regs("R1 reset");

    wr(4'h0, 32'hDEAD_BEEF); check_regs("R3 data write");
    wr(4'h4, 32'h000C_0000 | mk(0, 1, 0, 8, 0, 0, 0)); check_regs("R2 undefined bits");
    check("R4 no launch req", {30'd0, reboot_req, shutdown_req}, 32'd0);

    launch_chk("R6 shutdown", mk(1, 1, 0, 8, 0, 0, 0));
    launch_chk("R7 reboot", mk(1, 1, 0, 9, 0, 0, 0) | 32'h000C_0000);
    launch_chk("R5 dcc", mk(1, 1, 4'h1, 8, 0, 0, 0));
    launch_chk("R5 position", mk(1, 1, 0, 9, 0, 4'h2, 0));
    launch_chk("R5 site", mk(1, 1, 0, 8, 2'd2, 0, 0));
    launch_chk("R8 site1", mk(1, 1, 0, 8, 2'd1, 0, 0));
    launch_chk("R8 device", mk(1, 1, 0, 9, 0, 0, 12'h001));
    launch_chk("R8 read", mk(1, 0, 0, 8, 0, 0, 0));
    launch_chk("R8 other fn", mk(1, 1, 0, 5, 0, 0, 0));
    wr(4'h4, mk(0, 1, 0, 9, 0, 0, 0)); check_regs("R4 status held");

    // back-to-back: pulse of first launch coincides with decode of second
    wr(4'h4, mk(1, 1, 0, 8, 0, 0, 0));
    check("R6 b2b first", {30'd0, reboot_req, shutdown_req}, 32'd1);
    wr(4'h4, mk(1, 1, 0, 9, 0, 0, 0));
    check("R7 b2b second", {30'd0, reboot_req, shutdown_req}, 32'd2);
    wr(4'h4, mk(1, 1, 4'h3, 8, 0, 0, 0));
    check("R5 b2b reject", {30'd0, reboot_req, shutdown_req}, 32'd0);
    check_regs("R9 b2b");

    wr(4'hC, 32'hFFFF_FFFF); check_regs("R10 unmapped write");
    rd(4'hC, v); check("R10 unmapped read", v, 32'd0);

    for (int i = 0; i < 400; i++) begin
      int k;
      logic [31:0] w;
      k = $urandom % 8;
      if (k == 0) begin
        wr(4'h0, $urandom); check_regs("R3 random data");
      end else begin
        w = mk($urandom % 4 != 0, $urandom % 4 != 0,
               ($urandom % 4 == 0) ? 4'($urandom) : 4'd0,
               ($urandom % 3 == 0) ? 6'($urandom) : (($urandom % 2 == 1) ? 6'd8 : 6'd9),
               2'($urandom), ($urandom % 5 == 0) ? 4'($urandom) : 4'd0,
               ($urandom % 4 == 0) ? 12'($urandom) : 12'd0);
        w[19:18] = 2'($urandom);
        if (w[31]) launch_chk("R5 R6 R7 R8 random", w);
        else begin
          wr(4'h4, w);
          check("R4 random no launch", {30'd0, reboot_req, shutdown_req}, 32'd0);
          check_regs("R2 random");
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule